// File: doc/BRIEF.md
# Processor Operating Mode Controller

This block keeps track of which operating mode an x86-style core is in. It reads a small set of architectural control bits: protection enable, paging enable, long-mode enable, the virtual-8086 flag, and the long bit of the current code segment. It also takes two single-cycle event pulses, a system-management interrupt and a resume-from-management pulse. From these it reports the current mode as a 3-bit code and as a one-hot vector, together with a long-mode-active status bit.

A system-management interrupt can arrive in any ordinary mode. It moves the block into management mode and records the mode that was interrupted. A later resume pulse puts back exactly that recorded mode. Interrupts that arrive while already in management mode are counted in a saturating pending counter, and each one is served after the next resume.

All outputs come from registers. A change on the inputs or an event pulse shows up on the outputs one clock later.

Top module: `opmode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the block reports real mode (code 0), one-hot value 6'b000001, long-active 0, and nothing pending.
- R2: Outside management mode with nothing pending, prot_en_i=0 gives real mode (code 0) at the next clock. prot_en_i=1 gives protected mode (code 1) at the next clock when IA-32e is not active and v86_flag_i=0.
- R3: With prot_en_i=1, IA-32e not active and v86_flag_i=1, the next mode is virtual-8086 (code 2). Long-active is never 1 in virtual-8086 mode.
- R4: Long-active becomes 1 at the next clock when the registered mode is protected (code 1) and prot_en_i, paging_i and long_en_i are all 1. From real mode with all three bits set, the block goes to protected mode first and reaches IA-32e one clock later.
- R5: While long-active is 1, code_long_i=1 selects 64-bit sub-mode (code 4) and code_long_i=0 selects compatibility sub-mode (code 3). v86_flag_i has no effect on the mode.
- R6: In IA-32e, clearing paging_i gives protected mode (or virtual-8086 mode if v86_flag_i=1) with long-active 0 at the next clock. Clearing prot_en_i gives real mode with long-active 0.
- R7: smi_i outside management mode gives management mode (code 5) at the next clock and records the registered mode of that cycle. This takes priority over any input change in the same cycle.
- R8: resume_i in management mode gives back exactly the recorded mode at the next clock, whatever the control inputs do meanwhile. Long-active keeps its value throughout management mode.
- R9: Each smi_i received in management mode leaves the recorded mode unchanged and adds one to a pending count that saturates at 2^PEND_W-1 (3 by default). Outside management mode, a nonzero count causes entry at the next clock, consuming one count. resume_i outside management mode is ignored.
- R10: The one-hot output has exactly one bit set, at the index equal to the mode code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en_i | input | 1 | Protection enable control bit |
| paging_i | input | 1 | Paging enable control bit |
| long_en_i | input | 1 | Long-mode enable control bit |
| v86_flag_i | input | 1 | Virtual-8086 flag |
| code_long_i | input | 1 | Long bit of the current code segment |
| smi_i | input | 1 | System-management interrupt pulse |
| resume_i | input | 1 | Resume-from-management pulse |
| mode_o | output | 3 | Encoded mode: 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit, 5 management |
| mode_onehot_o | output | 6 | One-hot mode, bit index equals the code |
| long_active_o | output | 1 | Long-mode-active status |

## Verification
Two pairs of events can fall in the same cycle. The first is a management interrupt together with a change on the architectural inputs, for example clearing paging while in 64-bit mode. The second is a new interrupt together with a resume while already in management mode. Directed steps drive both collisions. The result is judged by whether the block enters management mode with the pre-change mode recorded, or resumes first and then re-enters from the pending count one clock later. Seeded random traffic with frequent pulses repeats these collisions, and every cycle is compared against a reference model written from the requirements.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

   localparam int MODE_W    = 3;
   localparam int NUM_MODES = 6;

   typedef enum logic [MODE_W-1:0] {
      MODE_REAL   = 3'd0,
      MODE_PROT   = 3'd1,
      MODE_V86    = 3'd2,
      MODE_COMPAT = 3'd3,
      MODE_LONG64 = 3'd4,
      MODE_SMM    = 3'd5
   } opmode_e;

endpackage

// File: rtl/opmode_arch_sel.sv
// Combinational choice of the next ordinary (non-management) mode.
module opmode_arch_sel
   import opmode_pkg::*;
(
   input  opmode_e cur_mode_i,
   input  logic    lma_cur_i,
   input  logic    prot_en_i,
   input  logic    paging_i,
   input  logic    long_en_i,
   input  logic    v86_flag_i,
   input  logic    code_long_i,
   output opmode_e next_mode_o,
   output logic    next_lma_o
);

   logic from_prot;
   logic lma_n;

   assign from_prot = (cur_mode_i == MODE_PROT);
   // Long mode turns on only from protected mode and stays on while paged.
   assign lma_n = prot_en_i & paging_i & (lma_cur_i | (from_prot & long_en_i));

   always_comb begin
      if (!prot_en_i)
         next_mode_o = MODE_REAL;
      else if (lma_n)
         next_mode_o = code_long_i ? MODE_LONG64 : MODE_COMPAT;
      else if (v86_flag_i)
         next_mode_o = MODE_V86;
      else
         next_mode_o = MODE_PROT;
   end

   assign next_lma_o = lma_n;

endmodule

// File: rtl/opmode_smm_ctx.sv
// Records the interrupted mode and counts interrupts pending during management mode.
module opmode_smm_ctx
   import opmode_pkg::*;
#(
   parameter int PEND_W = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    in_smm_i,
   input  logic    smi_i,
   input  logic    resume_i,
   input  opmode_e cur_mode_i,
   output logic    enter_o,
   output logic    leave_o,
   output opmode_e saved_mode_o,
   output logic    pend_nz_o
);

   localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

   logic [PEND_W-1:0] pend_q;
   opmode_e           saved_q;

   assign pend_nz_o = (pend_q != '0);
   assign enter_o   = !in_smm_i && (smi_i || pend_nz_o);
   assign leave_o   = in_smm_i && resume_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         saved_q <= MODE_REAL;
         pend_q  <= '0;
      end else begin
         if (enter_o)
            saved_q <= cur_mode_i;
         if (in_smm_i) begin
            if (smi_i && pend_q != PEND_MAX)
               pend_q <= pend_q + 1'b1;
         end else if (enter_o && !smi_i && pend_nz_o) begin
            pend_q <= pend_q - 1'b1;
         end
      end
   end

   assign saved_mode_o = saved_q;

   // R9
   saved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_smm_i |=> $stable(saved_q));

   // R9
   pend_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_smm_i && pend_q == PEND_MAX) |=> (pend_q == PEND_MAX));

   // R7
   saved_not_smm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enter_o |=> (saved_q != MODE_SMM));

endmodule

// File: rtl/opmode_onehot.sv
// Expands an encoded mode into a one-hot vector.
module opmode_onehot #(
   parameter int CODE_W = 3,
   parameter int NUM    = 6
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [NUM-1:0]    onehot_o
);

   for (genvar i = 0; i < NUM; i++) begin : g_bit
      assign onehot_o[i] = (code_i == CODE_W'(i));
   end

endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
   import opmode_pkg::*;
#(
   parameter int PEND_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 prot_en_i,
   input  logic                 paging_i,
   input  logic                 long_en_i,
   input  logic                 v86_flag_i,
   input  logic                 code_long_i,
   input  logic                 smi_i,
   input  logic                 resume_i,
   output logic [MODE_W-1:0]    mode_o,
   output logic [NUM_MODES-1:0] mode_onehot_o,
   output logic                 long_active_o
);

   localparam int PW = (PEND_W < 1) ? 1 : PEND_W;

   opmode_e mode_q;
   logic    lma_q;
   opmode_e arch_mode;
   logic    arch_lma;
   logic    in_smm;
   logic    enter;
   logic    leave;
   logic    pend_nz;
   opmode_e saved_mode;

   assign in_smm = (mode_q == MODE_SMM);

   opmode_arch_sel u_arch (
      .cur_mode_i  (mode_q),
      .lma_cur_i   (lma_q),
      .prot_en_i   (prot_en_i),
      .paging_i    (paging_i),
      .long_en_i   (long_en_i),
      .v86_flag_i  (v86_flag_i),
      .code_long_i (code_long_i),
      .next_mode_o (arch_mode),
      .next_lma_o  (arch_lma)
   );

   opmode_smm_ctx #(.PEND_W(PW)) u_smm (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_smm_i     (in_smm),
      .smi_i        (smi_i),
      .resume_i     (resume_i),
      .cur_mode_i   (mode_q),
      .enter_o      (enter),
      .leave_o      (leave),
      .saved_mode_o (saved_mode),
      .pend_nz_o    (pend_nz)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_REAL;
         lma_q  <= 1'b0;
      end else if (enter) begin
         mode_q <= MODE_SMM;
      end else if (leave) begin
         mode_q <= saved_mode;
      end else if (!in_smm) begin
         mode_q <= arch_mode;
         lma_q  <= arch_lma;
      end
   end

   opmode_onehot #(.CODE_W(MODE_W), .NUM(NUM_MODES)) u_oh (
      .code_i   (mode_q),
      .onehot_o (mode_onehot_o)
   );

   assign mode_o        = mode_q;
   assign long_active_o = lma_q;

   // R3
   v86_no_lma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_V86) |-> !lma_q);

   // R5
   lma_mode_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_SMM) |-> (lma_q == (mode_q == MODE_COMPAT || mode_q == MODE_LONG64)));

   // R2
   real_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_SMM && !smi_i && !pend_nz && !prot_en_i) |=> (mode_q == MODE_REAL && !lma_q));

   // R7
   smi_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_SMM && smi_i) |=> (mode_q == MODE_SMM));

   // R8
   resume_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SMM && resume_i) |=> (mode_q == $past(saved_mode)));

   // R8
   lma_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SMM) |=> $stable(lma_q));

   // R10
   onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(mode_onehot_o) == 1 && mode_onehot_o[mode_q]));

endmodule

// File: tb/tb_opmode_ctrl.sv
`timescale 1ns/1ps
module tb_opmode_ctrl;

   localparam int PEND_W   = 2;
   localparam int PEND_MAX = (1 << PEND_W) - 1;

   logic clk = 1'b0;
   logic rst_n;
   logic pe, pg, lme, vm, csl, smi, rsm;
   logic [2:0] mode;
   logic [5:0] oh;
   logic lma;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model state
   int em, es, ep;
   bit el;

   always #10 clk = ~clk;

   opmode_ctrl #(.PEND_W(PEND_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .prot_en_i(pe), .paging_i(pg), .long_en_i(lme), .v86_flag_i(vm),
      .code_long_i(csl), .smi_i(smi), .resume_i(rsm),
      .mode_o(mode), .mode_onehot_o(oh), .long_active_o(lma)
   );

   // Expected next state, computed from the requirements.
   task automatic model_update();
      bit nl;
      if (em != 5 && (smi || ep != 0)) begin
         es = em;
         em = 5;
         if (!smi && ep > 0) ep--;
      end else if (em == 5) begin
         if (smi && ep < PEND_MAX) ep++;
         if (rsm) em = es;
      end else begin
         nl = pe && pg && (el || (em == 1 && lme));
         if (!pe) em = 0;
         else if (nl) em = csl ? 4 : 3;
         else em = vm ? 2 : 1;
         el = nl;
      end
   endtask

   task automatic compare(input string tag);
      checks++;
      if (mode !== em[2:0] || oh !== (6'b1 << em) || lma !== el) begin
         errors++;
         $display("FAIL %s: mode=%0d oh=%b lma=%0b expected mode=%0d oh=%b lma=%0b",
                  tag, mode, oh, lma, em, 6'b1 << em, el);
      end
   endtask

   task automatic lit(input int m, input bit l, input string tag);
      checks++;
      if (mode !== m[2:0] || lma !== l) begin
         errors++;
         $display("FAIL %s: mode=%0d lma=%0b expected mode=%0d lma=%0b", tag, mode, lma, m, l);
      end
   endtask

   task automatic step(input bit a_pe, a_pg, a_lme, a_vm, a_csl, a_smi, a_rsm, input string tag);
      pe = a_pe; pg = a_pg; lme = a_lme; vm = a_vm; csl = a_csl; smi = a_smi; rsm = a_rsm;
      model_update();
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   function automatic string rand_tag(input int prev);
      if (smi || prev == 5) return "R9_R7_R8 random";
      if (!pe) return "R2 random";
      if (em == 3 || em == 4) return "R5 random";
      if (em == 2) return "R3 random";
      return "R4_R6 random";
   endfunction

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1: run did not finish, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      pe = 0; pg = 0; lme = 0; vm = 0; csl = 0; smi = 0; rsm = 0;
      em = 0; el = 0; es = 0; ep = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      lit(0, 0, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      lit(0, 0, "R1 after reset");
      compare("R1 onehot after reset");

      // R2 protection enable
      step(1,0,0,0,0,0,0, "R2 enable"); lit(1, 0, "R2 protected");
      step(0,0,0,0,0,0,0, "R2 disable"); lit(0, 0, "R2 real");
      step(1,0,0,0,0,0,0, "R2 enable again");
      // R3 v86
      step(1,0,0,1,0,0,0, "R3 v86"); lit(2, 0, "R3 v86 code");
      step(1,0,0,0,0,0,0, "R3 back"); lit(1, 0, "R3 back to protected");
      // R4 from real with all bits set: protected first, then IA-32e
      step(0,0,0,0,0,0,0, "R4 to real");
      step(1,1,1,0,1,0,0, "R4 first step"); lit(1, 0, "R4 protected first");
      step(1,1,1,0,1,0,0, "R4 second step"); lit(4, 1, "R4 long active");
      // R5 sub-modes, vm ignored
      step(1,1,1,0,0,0,0, "R5 compat"); lit(3, 1, "R5 compat code");
      step(1,1,1,1,0,0,0, "R5 vm ignored"); lit(3, 1, "R5 vm ignored code");
      step(1,1,1,1,1,0,0, "R5 64-bit"); lit(4, 1, "R5 64-bit code");
      // R7 smi with simultaneous paging drop
      step(1,0,1,0,1,1,0, "R7 collision"); lit(5, 1, "R7 smm with lma held");
      step(0,0,0,0,0,0,0, "R8 inputs move in smm"); lit(5, 1, "R8 still smm");
      step(0,0,0,0,0,0,1, "R8 resume"); lit(4, 1, "R8 exact restore");
      step(0,0,0,0,0,0,0, "R6 pe drop"); lit(0, 0, "R6 real lma clear");
      // R6 paging drop in long mode
      step(1,1,1,0,1,0,0, "R6 prot");
      step(1,1,1,0,1,0,0, "R6 long"); lit(4, 1, "R6 long reached");
      step(1,0,1,0,1,0,0, "R6 pg drop"); lit(1, 0, "R6 protected lma clear");
      // R9 resume outside smm ignored
      step(1,0,0,0,0,0,1, "R9 stray resume"); lit(1, 0, "R9 resume ignored");
      // R9 pending saturation
      step(1,0,0,0,0,1,0, "R9 enter"); lit(5, 0, "R9 smm");
      for (int i = 0; i < 4; i++) step(1,0,0,0,0,1,0, "R9 nested smi");
      step(1,0,0,0,0,0,1, "R9 resume 1"); lit(1, 0, "R9 restored 1");
      for (int k = 0; k < PEND_MAX; k++) begin
         step(1,0,0,0,0,0,0, "R9 pending reentry"); lit(5, 0, "R9 reentered");
         step(1,0,0,0,0,0,1, "R9 resume n"); lit(1, 0, "R9 restored n");
      end
      step(1,0,0,0,0,0,0, "R9 drained"); lit(1, 0, "R9 no more pending");
      // smi and resume together in smm
      step(0,0,0,0,0,0,0, "R7 real");
      step(0,0,0,0,0,1,0, "R7 smi from real"); lit(5, 0, "R7 smm from real");
      step(1,0,0,0,0,1,1, "R9 smi with resume"); lit(0, 0, "R8 resume to real");
      step(1,0,0,0,0,0,0, "R9 reentry after collision"); lit(5, 0, "R9 reentered");
      step(1,0,0,0,0,0,1, "R8 resume again"); lit(0, 0, "R8 real restored");

      // random phase
      void'($urandom(32'd20240611));
      for (int n = 0; n < 4000; n++) begin
         int prev;
         prev = em;
         pe  = ($urandom % 8) != 0;
         pg  = ($urandom % 4) != 0;
         lme = ($urandom % 4) != 0;
         vm  = ($urandom % 3) == 0;
         csl = $urandom % 2;
         smi = ($urandom % 16) == 0;
         rsm = ($urandom % 6) == 0;
         model_update();
         @(posedge clk);
         @(negedge clk);
         compare(rand_tag(prev));
         compare("R10 onehot random");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule